// File: doc/BRIEF.md
# Camera Stream Capture Front-End

This block takes pixels from a parallel camera port that runs on the camera's own pixel clock. It hands them to processing logic that runs on an unrelated system clock. The camera side never samples anything with the system clock. On each rising pixel-clock edge, the capture stage looks at the frame-active and line-active strobes. It turns every accepted pixel into a FIFO word that carries the pixel value and two framing flags: first pixel of the frame, and last pixel of the line.

The words cross into the system domain through an asynchronous FIFO. Its read and write pointers are Gray coded, and each pointer is synchronized into the opposite domain. On the system side, a two-state machine pops a word whenever the FIFO holds one. It presents the word as a valid/ready stream, so a downstream filter can consume the frame in raster order with the framing intact.

The frame size is not fixed in hardware. A CIF frame (352 x 288) and much smaller test frames pass through the same logic. If the FIFO is full when a pixel must be stored, the pixel is dropped and a sticky overflow flag is raised in the system domain.

Top module: `cam_capture_frontend`

## Requirements
- R1: While `rst` is high and afterwards until a pixel has been captured, `m_valid` and `overflow` are low.
- R2: A pixel is captured only at a rising `pclk` edge where `cam_vsync` and `cam_href` are both high. `cam_data` at any other edge (frame blanking, line blanking, or a line strobe outside a frame) produces no output word.
- R3: Every captured pixel appears on `m_data` exactly once, in capture order, unless it was dropped under R7.
- R4: `m_sof` is high on the first captured pixel after reset and on the first pixel captured after any `pclk` edge with `cam_vsync` low. It is low on all other words.
- R5: `m_eol` is high on a pixel when the next rising `pclk` edge no longer has both `cam_vsync` and `cam_href` high. This covers a line that ends by `cam_href` falling and one that ends by `cam_vsync` falling. A line one pixel wide carries both flags.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_sof` and `m_eol` hold their values at the next `sys_clk` edge.
- R7: A pixel that arrives while the FIFO (2**`FIFO_AW` words, plus the one word held at the output) is full is discarded. Words already stored are still delivered in order. `overflow` rises and stays high until `rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Pixel clock supplied by the camera |
| sys_clk | input | 1 | Processing clock, asynchronous to `pclk` |
| rst | input | 1 | Active-high reset, synchronized separately into each domain |
| cam_vsync | input | 1 | Frame active strobe, high during a frame |
| cam_href | input | 1 | Line active strobe, high while a line's pixels are sent |
| cam_data | input | PIX_W | Pixel value from the camera |
| m_valid | output | 1 | Output word is valid |
| m_ready | input | 1 | Downstream accepts the word at this `sys_clk` edge |
| m_data | output | PIX_W | Pixel value |
| m_sof | output | 1 | Word is the first pixel of a frame |
| m_eol | output | 1 | Word is the last pixel of a line |
| overflow | output | 1 | Sticky: at least one pixel was lost to a full FIFO |

## Verification
A pixel is written into the FIFO one `pclk` edge after it is sampled, because its end-of-line flag is known only then. The write pointer then takes two `sys_clk` edges to cross, and the word is shown at the following edge. So a word is due roughly three to four system cycles after its write, and this varies by a cycle with clock phase. For that reason, the scoreboard compares words by order, not by cycle, and waits for the queue to drain within a generous bound.

The stall-hold rule of R6 is checked every system cycle, one cycle after a stall is seen. The overflow flag crosses through two flops, so it is sampled several `pclk` cycles after the lost pixel. The number of words delivered from a stalled oversized line is bounded by the FIFO depth plus the output word, with one word of slack for pointer-crossing delay.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
  // framing flags carried beside each pixel: {sof, eol}
  localparam int FLAG_W = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SHOW = 1'b1
  } out_state_e;
endpackage

// File: rtl/cam_rst_sync.sv
module cam_rst_sync (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  logic [1:0] shreg = 2'b11;

  always_ff @(posedge clk) begin
    shreg <= {shreg[0], rst_in};
  end

  assign rst_out = shreg[1];
endmodule

// File: rtl/cam_sync_bits.sv
module cam_sync_bits #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cam_pix_capture.sv
module cam_pix_capture #(
  parameter int PIX_W = 8,
  localparam int WORD_W = PIX_W + cam_cap_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync,
  input  logic              href,
  input  logic [PIX_W-1:0]  data,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);
  logic             active;
  logic             have;
  logic             sof_pend;
  logic             hold_sof;
  logic [PIX_W-1:0] hold_pix;

  assign active = vsync & href;

  // one pixel is held until the next edge shows whether the line continues
  always_ff @(posedge clk) begin
    if (rst) begin
      have     <= 1'b0;
      sof_pend <= 1'b1;
      hold_sof <= 1'b0;
      hold_pix <= '0;
    end else begin
      have <= active;
      if (active) begin
        hold_pix <= data;
        hold_sof <= sof_pend;
      end
      if (!vsync)      sof_pend <= 1'b1;
      else if (active) sof_pend <= 1'b0;
    end
  end

  assign push      = have;
  assign push_word = {hold_sof, ~active, hold_pix};
endmodule

// File: rtl/cam_gray_fifo.sv
module cam_gray_fifo #(
  parameter int W  = 10,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic         ovf,
  input  logic         rclk,
  input  logic         rrst,
  input  logic         re,
  output logic [W-1:0] rdata,
  output logic         empty
);
  logic [W-1:0] mem [DEPTH];

  logic [AW:0] wbin, wgray, wbin_nx, rgray_w;
  logic [AW:0] rbin, rgray, rbin_nx, wgray_r;
  logic        full;
  logic        do_wr, do_rd;

  // write side
  assign wbin_nx = wbin + 1'b1;
  assign full    = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
  assign do_wr   = we & ~full;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
      ovf   <= 1'b0;
    end else if (we) begin
      if (full) begin
        ovf <= 1'b1;
      end else begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (do_wr) mem[wbin[AW-1:0]] <= wdata;
  end

  // read side
  assign rbin_nx = rbin + 1'b1;
  assign empty   = (rgray == wgray_r);
  assign do_rd   = re & ~empty;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (do_rd) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  always_ff @(posedge rclk) begin
    if (do_rd) rdata <= mem[rbin[AW-1:0]];
  end

  cam_sync_bits #(.W(AW + 1)) u_w2r (
    .clk (rclk),
    .rst (rrst),
    .d   (wgray),
    .q   (wgray_r)
  );

  cam_sync_bits #(.W(AW + 1)) u_r2w (
    .clk (wclk),
    .rst (wrst),
    .d   (rgray),
    .q   (rgray_w)
  );
endmodule

// File: rtl/cam_stream_fsm.sv
module cam_stream_fsm (
  input  logic clk,
  input  logic rst,
  input  logic empty,
  input  logic m_ready,
  output logic re,
  output logic m_valid
);
  import cam_cap_pkg::*;

  out_state_e state;

  always_comb begin
    re = ~empty & ((state == ST_IDLE) | m_ready);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (!empty)           state <= ST_SHOW;
        ST_SHOW: if (m_ready && empty) state <= ST_IDLE;
        default:                       state <= ST_IDLE;
      endcase
    end
  end

  assign m_valid = (state == ST_SHOW);
endmodule

// File: rtl/cam_capture_frontend.sv
module cam_capture_frontend #(
  parameter int PIX_W   = 8,
  parameter int FIFO_AW = 4
) (
  input  logic             pclk,
  input  logic             sys_clk,
  input  logic             rst,
  input  logic             cam_vsync,
  input  logic             cam_href,
  input  logic [PIX_W-1:0] cam_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PIX_W-1:0] m_data,
  output logic             m_sof,
  output logic             m_eol,
  output logic             overflow
);
  localparam int WORD_W = PIX_W + cam_cap_pkg::FLAG_W;

  logic              rst_pix, rst_sys;
  logic              cap_push;
  logic [WORD_W-1:0] cap_word;
  logic              ovf_pix;
  logic              fifo_re, fifo_empty;
  logic [WORD_W-1:0] fifo_rdata;

  cam_rst_sync u_rst_pix (.clk(pclk),    .rst_in(rst), .rst_out(rst_pix));
  cam_rst_sync u_rst_sys (.clk(sys_clk), .rst_in(rst), .rst_out(rst_sys));

  cam_pix_capture #(.PIX_W(PIX_W)) u_cap (
    .clk       (pclk),
    .rst       (rst_pix),
    .vsync     (cam_vsync),
    .href      (cam_href),
    .data      (cam_data),
    .push      (cap_push),
    .push_word (cap_word)
  );

  cam_gray_fifo #(.W(WORD_W), .AW(FIFO_AW)) u_fifo (
    .wclk  (pclk),
    .wrst  (rst_pix),
    .we    (cap_push),
    .wdata (cap_word),
    .ovf   (ovf_pix),
    .rclk  (sys_clk),
    .rrst  (rst_sys),
    .re    (fifo_re),
    .rdata (fifo_rdata),
    .empty (fifo_empty)
  );

  cam_stream_fsm u_fsm (
    .clk     (sys_clk),
    .rst     (rst_sys),
    .empty   (fifo_empty),
    .m_ready (m_ready),
    .re      (fifo_re),
    .m_valid (m_valid)
  );

  cam_sync_bits #(.W(1)) u_ovf_sync (
    .clk (sys_clk),
    .rst (rst_sys),
    .d   (ovf_pix),
    .q   (overflow)
  );

  assign m_sof  = fifo_rdata[WORD_W-1];
  assign m_eol  = fifo_rdata[WORD_W-2];
  assign m_data = fifo_rdata[PIX_W-1:0];
endmodule

// File: rtl/cam_capture_frontend_chk.sv
module cam_capture_frontend_chk #(
  parameter int PIX_W = 8
) (
  input logic             pclk,
  input logic             sys_clk,
  input logic             rst_pix,
  input logic             rst_sys,
  input logic             cam_vsync,
  input logic             cam_href,
  input logic             cap_push,
  input logic             fifo_empty,
  input logic             m_valid,
  input logic             m_ready,
  input logic [PIX_W-1:0] m_data,
  input logic             m_sof,
  input logic             m_eol,
  input logic             overflow
);
  AST_NO_PUSH_IDLE: assert property (@(posedge pclk) disable iff (rst_pix)
    !(cam_vsync && cam_href) |=> !cap_push); // R2

  AST_VALID_FROM_FIFO: assert property (@(posedge sys_clk) disable iff (rst_sys)
    $rose(m_valid) |-> $past(!fifo_empty)); // R3

  AST_STALL_VALID: assert property (@(posedge sys_clk) disable iff (rst_sys)
    (m_valid && !m_ready) |=> m_valid); // R6

  AST_STALL_DATA: assert property (@(posedge sys_clk) disable iff (rst_sys)
    (m_valid && !m_ready) |=> ($stable(m_data) && $stable(m_sof) && $stable(m_eol))); // R6

  AST_OVF_STICKY: assert property (@(posedge sys_clk) disable iff (rst_sys)
    overflow |=> overflow); // R7
endmodule

bind cam_capture_frontend cam_capture_frontend_chk #(.PIX_W(PIX_W)) u_chk (
  .pclk       (pclk),
  .sys_clk    (sys_clk),
  .rst_pix    (rst_pix),
  .rst_sys    (rst_sys),
  .cam_vsync  (cam_vsync),
  .cam_href   (cam_href),
  .cap_push   (cap_push),
  .fifo_empty (fifo_empty),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_data     (m_data),
  .m_sof      (m_sof),
  .m_eol      (m_eol),
  .overflow   (overflow)
);

// File: tb/cam_capture_frontend_bench.sv
module cam_capture_frontend_bench;
  localparam int PIX_W   = 8;
  localparam int FIFO_AW = 4;
  localparam int DEPTH   = 1 << FIFO_AW;

  logic             pclk = 1'b0;
  logic             sys_clk = 1'b0;
  logic             rst = 1'b1;
  logic             cam_vsync = 1'b0;
  logic             cam_href = 1'b0;
  logic [PIX_W-1:0] cam_data = '0;
  logic             m_ready = 1'b0;
  logic             m_valid;
  logic [PIX_W-1:0] m_data;
  logic             m_sof, m_eol, overflow;

  int n_checks = 0;
  int n_fail   = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [PIX_W+1:0] exp_q[$];
  bit stall_prev = 1'b0;
  logic [PIX_W+1:0] held_word = '0;

  always #4  sys_clk = ~sys_clk;   // 125 MHz
  always #11 pclk    = ~pclk;

  cam_capture_frontend #(.PIX_W(PIX_W), .FIFO_AW(FIFO_AW)) u_cam_capture_frontend (
    .pclk      (pclk),
    .sys_clk   (sys_clk),
    .rst       (rst),
    .cam_vsync (cam_vsync),
    .cam_href  (cam_href),
    .cam_data  (cam_data),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .m_sof     (m_sof),
    .m_eol     (m_eol),
    .overflow  (overflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // driver: one frame, expected words pushed to the scoreboard
  task automatic send_frame(input int lines, input int width, input int base,
                            input bit abrupt_end);
    for (int i = 0; i < 3; i++) begin      // line strobe outside a frame (R2)
      @(negedge pclk); cam_vsync = 1'b0; cam_href = 1'b1; cam_data = 8'hEE;
    end
    @(negedge pclk); cam_href = 1'b0;
    @(negedge pclk); cam_vsync = 1'b1;
    for (int ln = 0; ln < lines; ln++) begin
      for (int b = 0; b < 2; b++) begin    // line blanking, data moving (R2)
        @(negedge pclk); cam_href = 1'b0; cam_data = 8'h55 + 8'(b);
      end
      for (int p = 0; p < width; p++) begin
        @(negedge pclk);
        cam_href = 1'b1;
        cam_data = 8'(base + ln * 31 + p * 7);
        exp_q.push_back({(ln == 0 && p == 0), (p == width - 1), cam_data});
      end
    end
    @(negedge pclk);
    if (abrupt_end) begin
      cam_vsync = 1'b0;                    // line ends by frame strobe (R5)
    end else begin
      cam_href = 1'b0;
      @(negedge pclk);
      cam_vsync = 1'b0;
    end
    @(negedge pclk); cam_vsync = 1'b0; cam_href = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(posedge sys_clk);
    check(exp_q.size() == 0, req, "words still missing", exp_q.size(), 0);
  endtask

  // monitor / scoreboard
  always @(negedge sys_clk) begin
    if (rst) begin
      m_ready = 1'b0;
      stall_prev = 1'b0;
    end else begin
      if (stall_prev) begin
        check(m_valid == 1'b1, "R6", "valid dropped during stall", m_valid, 1);
        check({m_sof, m_eol, m_data} == held_word, "R6", "word changed during stall",
              {m_sof, m_eol, m_data}, held_word);
      end
      case (ready_mode)
        0: m_ready = 1'b1;
        1: begin
             lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
             m_ready = lfsr[0];
           end
        default: m_ready = 1'b0;
      endcase
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected word", m_data, 0);
        end else begin
          logic [PIX_W+1:0] e;
          e = exp_q.pop_front();
          check(m_data == e[PIX_W-1:0], "R3", "pixel value", m_data, e[PIX_W-1:0]);
          check(m_sof == e[PIX_W+1], "R4", "start-of-frame flag", m_sof, e[PIX_W+1]);
          check(m_eol == e[PIX_W], "R5", "end-of-line flag", m_eol, e[PIX_W]);
        end
      end
      stall_prev = m_valid && !m_ready;
      held_word  = {m_sof, m_eol, m_data};
    end
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    check(1'b0, "R3", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int delivered;
    rst = 1'b1;
    repeat (6) @(posedge pclk);
    @(negedge sys_clk);
    check(m_valid == 1'b0, "R1", "valid in reset", m_valid, 0);
    check(overflow == 1'b0, "R1", "overflow in reset", overflow, 0);
    @(negedge pclk); rst = 1'b0;
    repeat (8) @(negedge pclk);
    check(m_valid == 1'b0, "R1", "valid with nothing captured", m_valid, 0);

    ready_mode = 0;                        // R2 R3 R4 R5 plain frame
    send_frame(3, 12, 8'h10, 1'b0);
    wait_drain("R3");

    ready_mode = 1;                        // R6 random stalls, R5 abrupt end
    send_frame(4, 9, 8'h40, 1'b1);
    wait_drain("R6");

    send_frame(3, 1, 8'h21, 1'b0);         // R4 R5 one-pixel lines
    wait_drain("R5");
    check(overflow == 1'b0, "R7", "overflow without a full FIFO", overflow, 0);

    ready_mode = 2;                        // R7 overfill while stalled
    send_frame(1, 20, 8'h80, 1'b0);
    repeat (10) @(negedge pclk);
    @(negedge sys_clk);
    check(overflow == 1'b1, "R7", "overflow after loss", overflow, 1);
    ready_mode = 0;
    repeat (300) @(posedge sys_clk);
    delivered = 20 - exp_q.size();
    check(delivered == DEPTH || delivered == DEPTH + 1, "R7", "words kept when full",
          delivered, DEPTH + 1);
    exp_q.delete();

    ready_mode = 1;                        // R7 recovery, flag sticky
    send_frame(2, 6, 8'hC0, 1'b0);
    wait_drain("R7");
    check(overflow == 1'b1, "R7", "overflow not sticky", overflow, 1);

    @(negedge pclk); rst = 1'b1;
    repeat (6) @(posedge pclk);
    @(negedge pclk); rst = 1'b0;
    repeat (6) @(negedge pclk);
    @(negedge sys_clk);
    check(overflow == 1'b0, "R7", "overflow after reset", overflow, 0);
    check(m_valid == 1'b0, "R1", "valid after reset", m_valid, 0);

    summary();
  end
endmodule